// File: doc/BRIEF.md
# Processor Register Bank with Guarded Special Slots

A 32-bit register bank for a small in-order processor core. It holds sixteen general-purpose registers and four named working registers: an accumulator, a stack pointer, a frame pointer and a link register. The same select space also maps a constant-zero slot, a read-only view of the program counter, two privileged configuration registers (an interrupt-table base and a memory-map base), and a range of void selects that must never be used.

Two combinational read ports and one write port share that select space. The write port merges the incoming value in one of three ways: a whole-word write, a lower-half immediate that clears the upper half, and an upper-half immediate that keeps the lower half. The bank classifies every select and flags illegal accesses on per-port fault outputs. A faulted write leaves every register unchanged. The instruction decoder drives the selects and the current privilege level and reacts to the faults. The program-counter value itself comes from outside the block.

Top module: `sreg_file`

## Requirements
- R1: Selects 0 to 15 address the general-purpose registers, and selects 16 (accumulator), 17 (stack pointer), 18 (frame pointer) and 19 (link register) address the working registers. A write to any of them can be read back on either read port.
- R2: Select 20 is the zero slot. It always reads 0 without a fault, and a write to it is dropped without a fault.
- R3: Select 21 reads the `pc_value` input. A write to it raises `wr_fault` in the same cycle and stores nothing.
- R4: Selects 22 and 23 are privileged. With `kernel_mode` low, a read raises that port's fault and returns 0, and a write raises `wr_fault` and stores nothing. With `kernel_mode` high, they behave as plain registers.
- R5: Selects 24 to 31 are void. A read faults and returns 0, and a write faults and stores nothing.
- R6: With `wr_mode` = 1 (lower immediate), the register receives `wr_data[15:0]` in bits 15:0, and bits 31:16 are cleared.
- R7: With `wr_mode` = 2 (upper immediate), the register receives `wr_data[15:0]` in bits 31:16, and bits 15:0 keep their old value.
- R8: With `wr_mode` = 0 or 3, the whole 32-bit `wr_data` is stored.
- R9: Reads are combinational. A write takes effect at the rising clock edge, so a read of the register being written in that same cycle returns the old value.
- R10: A synchronous active-high `rst` clears every storing register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| kernel_mode | input | 1 | High when the current access is privileged |
| pc_value | input | 32 | Program counter, shown at select 21 |
| rd_a_sel | input | 5 | Read port A select |
| rd_a_data | output | 32 | Read port A data |
| rd_a_fault | output | 1 | Read port A illegal access |
| rd_b_sel | input | 5 | Read port B select |
| rd_b_data | output | 32 | Read port B data |
| rd_b_fault | output | 1 | Read port B illegal access |
| wr_en | input | 1 | Write request |
| wr_sel | input | 5 | Write select |
| wr_mode | input | 2 | 0/3 word, 1 lower immediate, 2 upper immediate |
| wr_data | input | 32 | Write value; immediates come from bits 15:0 |
| wr_fault | output | 1 | Illegal write, same cycle |

## Verification
A read and a write can target the same register in one cycle. That collision matters most for the upper-immediate merge, which must combine the old lower half with the new upper half while the read port still shows the old value. The bench provokes it by driving both read selects equal to the write select during directed merges and at random. It judges the pre-edge sample against the old model value and the following cycle against the merged value. The same cycles also combine privilege changes with faulting writes, to confirm that a rejected write leaves the targeted register unchanged.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   typedef enum logic [2:0] {
      K_STORE = 3'd0,
      K_ZERO  = 3'd1,
      K_PCV   = 3'd2,
      K_PRIV  = 3'd3,
      K_VOID  = 3'd4
   } kind_e;

   localparam logic [1:0] WM_LO = 2'd1;
   localparam logic [1:0] WM_HI = 2'd2;

   // Select layout: GP block, four working regs, zero, pc view, two privileged, then void.
   function automatic kind_e classify(input int unsigned sel, input int unsigned ngp);
      if (sel < ngp + 4)        return K_STORE;
      else if (sel == ngp + 4)  return K_ZERO;
      else if (sel == ngp + 5)  return K_PCV;
      else if (sel < ngp + 8)   return K_PRIV;
      else                      return K_VOID;
   endfunction

endpackage

// File: rtl/sreg_access.sv
module sreg_access
   import sreg_pkg::*;
#(
   parameter int NGP = 16,
   parameter int SW  = 5,
   parameter bit IS_WRITE = 1'b0
) (
   input  logic [SW-1:0] sel,
   input  logic          kernel,
   output kind_e         kind,
   output logic          fault
);
   always_comb begin
      kind  = classify(int'(unsigned'(sel)), NGP);
      fault = 1'b0;
      case (kind)
         K_VOID:  fault = 1'b1;
         K_PRIV:  fault = !kernel;
         K_PCV:   fault = IS_WRITE;
         default: fault = 1'b0;
      endcase
   end
endmodule

// File: rtl/sreg_merge.sv
module sreg_merge #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] old_val,
   input  logic [DW-1:0] new_val,
   input  logic [1:0]    mode,
   output logic [DW-1:0] merged
);
   localparam int HALF = DW / 2;

   always_comb begin
      case (mode)
         sreg_pkg::WM_LO: merged = {{(DW-HALF){1'b0}}, new_val[HALF-1:0]};
         sreg_pkg::WM_HI: merged = {new_val[DW-HALF-1:0], old_val[HALF-1:0]};
         default:         merged = new_val;
      endcase
   end
endmodule

// File: rtl/sreg_rdport.sv
module sreg_rdport
   import sreg_pkg::*;
#(
   parameter int DW    = 32,
   parameter int NSLOT = 24,
   parameter int SW    = 5
) (
   input  logic [NSLOT-1:0][DW-1:0] slots,
   input  logic [SW-1:0]            sel,
   input  kind_e                    kind,
   input  logic                     fault,
   input  logic [DW-1:0]            pc_value,
   output logic [DW-1:0]            data
);
   always_comb begin
      data = '0;
      if (!fault) begin
         case (kind)
            K_PCV:          data = pc_value;
            K_STORE, K_PRIV: data = slots[sel];
            default:        data = '0;
         endcase
      end
   end
endmodule

// File: rtl/sreg_file.sv
module sreg_file
   import sreg_pkg::*;
#(
   parameter int DW  = 32,
   parameter int NGP = 16,
   parameter int SW  = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          kernel_mode,
   input  logic [DW-1:0] pc_value,
   input  logic [SW-1:0] rd_a_sel,
   output logic [DW-1:0] rd_a_data,
   output logic          rd_a_fault,
   input  logic [SW-1:0] rd_b_sel,
   output logic [DW-1:0] rd_b_data,
   output logic          rd_b_fault,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_sel,
   input  logic [1:0]    wr_mode,
   input  logic [DW-1:0] wr_data,
   output logic          wr_fault
);
   localparam int NSLOT = NGP + 8;
   localparam int NRP   = 2;

   if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
      $error("sreg_file: DW must be even and at least 2");
   end
   if (NSLOT >= (1 << SW)) begin : g_bad_sw
      $error("sreg_file: SW too narrow to leave a void select");
   end

   logic [NSLOT-1:0][DW-1:0] slots;
   logic [NRP-1:0][SW-1:0]   rsel;
   logic [NRP-1:0][DW-1:0]   rdata;
   logic [NRP-1:0]           rfault;

   assign rsel[0]    = rd_a_sel;
   assign rsel[1]    = rd_b_sel;
   assign rd_a_data  = rdata[0];
   assign rd_b_data  = rdata[1];
   assign rd_a_fault = rfault[0];
   assign rd_b_fault = rfault[1];

   // Read ports: classification and data selection per port
   for (genvar p = 0; p < NRP; p++) begin : g_rp
      kind_e rkind;
      sreg_access #(.NGP(NGP), .SW(SW), .IS_WRITE(1'b0)) i_acc (
         .sel    (rsel[p]),
         .kernel (kernel_mode),
         .kind   (rkind),
         .fault  (rfault[p])
      );
      sreg_rdport #(.DW(DW), .NSLOT(NSLOT), .SW(SW)) i_rd (
         .slots    (slots),
         .sel      (rsel[p]),
         .kind     (rkind),
         .fault    (rfault[p]),
         .pc_value (pc_value),
         .data     (rdata[p])
      );
   end

   // Write port
   kind_e         wkind;
   logic          wbad;
   logic [DW-1:0] wold;
   logic [DW-1:0] wmerged;
   logic          wcommit;

   sreg_access #(.NGP(NGP), .SW(SW), .IS_WRITE(1'b1)) i_wacc (
      .sel    (wr_sel),
      .kernel (kernel_mode),
      .kind   (wkind),
      .fault  (wbad)
   );

   assign wr_fault = wr_en && wbad;
   assign wcommit  = wr_en && !wbad;
   assign wold     = (wkind == K_STORE || wkind == K_PRIV) ? slots[wr_sel] : '0;

   sreg_merge #(.DW(DW)) i_merge (
      .old_val (wold),
      .new_val (wr_data),
      .mode    (wr_mode),
      .merged  (wmerged)
   );

   // Storage: flops only where the select space holds a writable register
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (classify(i, NGP) == K_STORE || classify(i, NGP) == K_PRIV) begin : g_ff
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wcommit && wr_sel == SW'(i))
               q <= wmerged;
         end
         assign slots[i] = q;
      end else begin : g_const
         assign slots[i] = '0;
      end
   end
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk #(
   parameter int DW  = 32,
   parameter int NGP = 16,
   parameter int SW  = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          kernel_mode,
   input logic [DW-1:0] pc_value,
   input logic [SW-1:0] rd_a_sel,
   input logic [DW-1:0] rd_a_data,
   input logic          rd_a_fault,
   input logic [SW-1:0] rd_b_sel,
   input logic [DW-1:0] rd_b_data,
   input logic          rd_b_fault,
   input logic          wr_en,
   input logic [SW-1:0] wr_sel,
   input logic [1:0]    wr_mode,
   input logic [DW-1:0] wr_data,
   input logic          wr_fault
);
   localparam int HALF = DW / 2;
   localparam logic [SW-1:0] ZI  = SW'(NGP + 4);
   localparam logic [SW-1:0] PI  = SW'(NGP + 5);
   localparam logic [SW-1:0] QA  = SW'(NGP + 6);
   localparam logic [SW-1:0] QB  = SW'(NGP + 7);

   AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
      rd_a_sel == ZI |-> rd_a_data == '0 && !rd_a_fault); // R2

   AST_PCV_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_sel == PI |-> wr_fault); // R3

   AST_PCV_READ: assert property (@(posedge clk) disable iff (rst)
      rd_b_sel == PI |-> rd_b_data == pc_value && !rd_b_fault); // R3

   AST_PRIV_USER: assert property (@(posedge clk) disable iff (rst)
      wr_en && !kernel_mode && (wr_sel == QA || wr_sel == QB) |-> wr_fault); // R4

   AST_VOID_FAULT: assert property (@(posedge clk) disable iff (rst)
      rd_a_sel > QB |-> rd_a_fault && rd_a_data == '0); // R5

   AST_LO_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && !wr_fault && wr_mode == 2'd1 && wr_sel < ZI)
      && rd_a_sel == $past(wr_sel) |-> rd_a_data[DW-1:HALF] == '0); // R6

   AST_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && !wr_fault && wr_mode == 2'd2 && wr_sel < ZI && rd_b_sel == wr_sel)
      && rd_b_sel == $past(wr_sel)
      |-> rd_b_data[HALF-1:0] == $past(rd_b_data[HALF-1:0])); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) && rd_a_sel < ZI |-> rd_a_data == '0); // R10
endmodule

bind sreg_file sreg_chk #(.DW(DW), .NGP(NGP), .SW(SW)) i_chk (.*);

// File: tb/test_sreg_file.sv
module test_sreg_file;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        kernel_mode = 1'b0;
   logic [31:0] pc_value = '0;
   logic [4:0]  rd_a_sel = '0;
   logic [31:0] rd_a_data;
   logic        rd_a_fault;
   logic [4:0]  rd_b_sel = '0;
   logic [31:0] rd_b_data;
   logic        rd_b_fault;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_sel = '0;
   logic [1:0]  wr_mode = '0;
   logic [31:0] wr_data = '0;
   logic        wr_fault;

   int checks = 0;
   int errors = 0;
   logic [31:0] m [0:23];

   always #2.5 clk = ~clk;

   sreg_file i_sreg_file (.*);

   function automatic bit is_void(input logic [4:0] s);  return s > 5'd23; endfunction
   function automatic bit is_priv(input logic [4:0] s);  return s == 5'd22 || s == 5'd23; endfunction

   function automatic bit exp_rfault(input logic [4:0] s, input logic k);
      return is_void(s) || (is_priv(s) && !k);
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [4:0] s, input logic k, input logic [31:0] pc);
      if (exp_rfault(s, k)) return '0;
      if (s == 5'd20) return '0;
      if (s == 5'd21) return pc;
      return m[s];
   endfunction

   function automatic bit exp_wfault(input logic [4:0] s, input logic k);
      return is_void(s) || s == 5'd21 || (is_priv(s) && !k);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [1:0] md);
      case (md)
         2'd1:    return {16'h0, d[15:0]};
         2'd2:    return {d[15:0], o[15:0]};
         default: return d;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check before the edge, update model at the edge.
   task automatic cyc(input string tag, input logic [4:0] ra, input logic [4:0] rb,
                      input logic we, input logic [4:0] ws, input logic [1:0] wm,
                      input logic [31:0] wd, input logic km);
      @(negedge clk);
      rd_a_sel = ra; rd_b_sel = rb; wr_en = we; wr_sel = ws; wr_mode = wm;
      wr_data = wd; kernel_mode = km; pc_value = $urandom;
      #1;
      chk({tag, " rdA"}, rd_a_data, exp_rdata(ra, km, pc_value));
      chk({tag, " rdB"}, rd_b_data, exp_rdata(rb, km, pc_value));
      chk({tag, " fA"}, 32'(rd_a_fault), 32'(exp_rfault(ra, km)));
      chk({tag, " fB"}, 32'(rd_b_fault), 32'(exp_rfault(rb, km)));
      chk({tag, " wfault"}, 32'(wr_fault), 32'(we && exp_wfault(ws, km)));
      @(posedge clk);
      if (we && !exp_wfault(ws, km) && ws != 5'd20) m[ws] = merge(m[ws], wd, wm);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0;
      repeat (3) @(posedge clk);
      for (int i = 0; i < 24; i++) m[i] = '0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 24; i++) m[i] = '0;
      void'($urandom(32'h5EED_1234));
      do_reset();
      // R10: all slots read zero after reset
      for (int i = 0; i < 24; i++) cyc("R10 reset", 5'(i), 5'(i), 1'b0, 0, 0, 0, 1'b1);

      // R1 / R8 / R9: word writes, same-cycle read shows old value
      for (int i = 0; i < 20; i++)
         cyc("R1 R8 R9 write", 5'(i), 5'(i), 1'b1, 5'(i), 2'(i % 2 ? 3 : 0), $urandom, 1'b0);
      for (int i = 0; i < 20; i++) cyc("R1 readback", 5'(i), 5'(19 - i), 1'b0, 0, 0, 0, 1'b0);

      // R2 zero slot
      cyc("R2 zero wr", 5'd20, 5'd20, 1'b1, 5'd20, 2'd0, 32'hFFFF_FFFF, 1'b1);
      cyc("R2 zero rd", 5'd20, 5'd20, 1'b0, 0, 0, 0, 1'b0);

      // R3 pc view
      cyc("R3 pc wr", 5'd21, 5'd21, 1'b1, 5'd21, 2'd0, 32'h1234_5678, 1'b1);
      cyc("R3 pc rd", 5'd21, 5'd21, 1'b0, 0, 0, 0, 1'b0);

      // R4 privileged slots
      cyc("R4 user wr", 5'd22, 5'd23, 1'b1, 5'd22, 2'd0, 32'hCAFE_0001, 1'b0);
      cyc("R4 kern rd", 5'd22, 5'd23, 1'b0, 0, 0, 0, 1'b1);
      cyc("R4 kern wr", 5'd22, 5'd23, 1'b1, 5'd23, 2'd0, 32'hCAFE_0002, 1'b1);
      cyc("R4 user rd", 5'd23, 5'd22, 1'b0, 0, 0, 0, 1'b0);
      cyc("R4 kern rd2", 5'd23, 5'd22, 1'b0, 0, 0, 0, 1'b1);

      // R5 void selects
      for (int i = 24; i < 32; i++)
         cyc("R5 void", 5'(i), 5'd3, 1'b1, 5'(i), 2'd0, 32'hDEAD_BEEF, 1'b1);
      cyc("R5 after", 5'd3, 5'd3, 1'b0, 0, 0, 0, 1'b1);

      // R6 / R7 merges, read port on the written register
      cyc("R8 seed", 5'd16, 5'd16, 1'b1, 5'd16, 2'd0, 32'hA5A5_C3C3, 1'b0);
      cyc("R6 lower", 5'd16, 5'd16, 1'b1, 5'd16, 2'd1, 32'hFFFF_1111, 1'b0);
      cyc("R6 check", 5'd16, 5'd16, 1'b0, 0, 0, 0, 1'b0);
      cyc("R7 upper", 5'd16, 5'd16, 1'b1, 5'd16, 2'd2, 32'h0000_BEEF, 1'b0);
      cyc("R7 check", 5'd16, 5'd16, 1'b0, 0, 0, 0, 1'b0);
      cyc("R7 priv upper", 5'd23, 5'd23, 1'b1, 5'd23, 2'd2, 32'h0000_7777, 1'b1);
      cyc("R7 priv check", 5'd23, 5'd23, 1'b0, 0, 0, 0, 1'b1);

      // Random mix with collisions between read and write selects
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] ws;
         logic [4:0] ra;
         logic [4:0] rb;
         ws = 5'($urandom_range(0, 31));
         ra = ($urandom_range(0, 3) == 0) ? ws : 5'($urandom_range(0, 31));
         rb = ($urandom_range(0, 3) == 0) ? ws : 5'($urandom_range(0, 31));
         cyc("random", ra, rb, 1'($urandom), ws, 2'($urandom), $urandom, 1'($urandom));
      end

      // R10 second reset clears written state
      do_reset();
      for (int i = 0; i < 24; i++) cyc("R10 reset2", 5'(i), 5'(23 - i), 1'b0, 0, 0, 0, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule